// File: doc/BRIEF.md
# I2C Programmed-I/O Command Dispatcher

This block is the programmed-I/O front end of a touch-controller interface. A host presents a command opcode together with an 8-bit register address, a data word and byte counts, then pulses a start strobe. The dispatcher decodes the opcode. A register opcode becomes one read or write on a simple APB-style register port. A bus opcode becomes one or two transaction requests to an I2C master engine. A bad opcode is refused at once. The command ends with a one-cycle done strobe, with an error flag when the command failed and the read result when there is one.

There are three bus opcodes. Each one drives a small phase sequence. A write-then-read command sends a write phase that leaves the bus held without a stop. It then sends a read phase that asks for a repeated start and ends with a stop. The bit-level I2C engine sits outside this block and answers each request with a done pulse, an error flag and read data.

Top module: `pio_dispatch`

## Requirements
- R1: After reset, cmd_done, cmd_err, reg_psel, reg_penable and xreq_valid are 0 and cmd_rdata is 0.
- R2: Opcode 0x12 does one register read. There is one setup cycle (reg_psel=1, reg_penable=0, reg_pwrite=0, reg_paddr=cmd_addr), then access cycles (reg_penable=1) held until reg_pready. reg_prdata appears on cmd_rdata with cmd_done one cycle after the access cycle that sees reg_pready. With no wait states, done comes 3 cycles after the start edge.
- R3: Opcode 0x13 does one register write with reg_pwrite=1 and reg_pwdata=cmd_wdata. It finishes with cmd_err=0 and cmd_rdata=0.
- R4: The register address is passed to reg_paddr unchanged over the whole range 0x00 to 0xFF.
- R5: Opcode 0x14 issues one request with xreq_read=1, xreq_len=cmd_rlen, xreq_rstart=0 and xreq_stop=1. The xrsp_rdata of that request becomes cmd_rdata.
- R6: Opcode 0x18 issues one request with xreq_read=0, xreq_len=cmd_wlen, xreq_wdata=cmd_wdata, xreq_rstart=0 and xreq_stop=1. cmd_rdata is 0.
- R7: Opcode 0x1C first issues a write request (xreq_read=0, xreq_len=cmd_wlen, xreq_stop=0, xreq_rstart=0). After its xrsp_done, xreq_valid drops for exactly one cycle. Then a read request follows (xreq_read=1, xreq_len=cmd_rlen, xreq_rstart=1, xreq_stop=1). The read data of that request becomes cmd_rdata. Each request is held steady until xrsp_done.
- R8: For opcodes 0x14, 0x18 and 0x1C, cmd_addr has no effect and the register port stays idle. The register port and the transaction request are never active together.
- R9: Any opcode other than the five above raises cmd_done and cmd_err together in the cycle after the start edge. It issues no register access and no transaction request.
- R10: An xrsp_done with xrsp_err=1 ends the command in the next cycle with cmd_done=1 and cmd_err=1. No later phase is issued and cmd_rdata stays 0.
- R11: cmd_start is ignored until the current command has returned cmd_done.
- R12: cmd_done is high for exactly one cycle per command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | Start strobe for a new command |
| cmd_op | input | 8 | Command opcode |
| cmd_addr | input | ADDR_W | Internal register address |
| cmd_wdata | input | DATA_W | Write data word |
| cmd_wlen | input | LEN_W | Byte count of the write phase |
| cmd_rlen | input | LEN_W | Byte count of the read phase |
| cmd_done | output | 1 | One-cycle completion strobe |
| cmd_err | output | 1 | Error flag, valid with cmd_done |
| cmd_rdata | output | DATA_W | Read result, 0 for writes and failures |
| reg_psel | output | 1 | Register port select |
| reg_penable | output | 1 | Register port access phase |
| reg_pwrite | output | 1 | Register port direction, 1 = write |
| reg_paddr | output | ADDR_W | Register port address |
| reg_pwdata | output | DATA_W | Register port write data |
| reg_prdata | input | DATA_W | Register port read data |
| reg_pready | input | 1 | Register port access complete |
| xreq_valid | output | 1 | Transaction request present |
| xreq_read | output | 1 | Request direction, 1 = read |
| xreq_len | output | LEN_W | Request byte count |
| xreq_wdata | output | DATA_W | Request write bytes |
| xreq_rstart | output | 1 | Repeated start before this phase |
| xreq_stop | output | 1 | Stop after this phase |
| xrsp_done | input | 1 | Engine finished the current request |
| xrsp_err | input | 1 | Engine reports a failed request |
| xrsp_rdata | input | DATA_W | Engine read bytes |

## Verification
The assertions assume two things about the engine and the register slave. The engine pulses xrsp_done only while a request is presented, and for one cycle per request. reg_pready matters only in an access cycle. The bench models both. The engine waits a fixed latency after it first sees a request, gives one done pulse, then waits for the request to drop before it accepts the next. The register slave raises reg_pready only after a set number of access cycles. The host stimulus drives one command at a time. The only exception is a deliberate start strobe sent while a command is in flight.

// File: rtl/pio_disp_pkg.sv
package pio_disp_pkg;

    localparam logic [7:0] OPC_REG_RD  = 8'h12;
    localparam logic [7:0] OPC_REG_WR  = 8'h13;
    localparam logic [7:0] OPC_BUS_RD  = 8'h14;
    localparam logic [7:0] OPC_BUS_WR  = 8'h18;
    localparam logic [7:0] OPC_BUS_WRD = 8'h1C;

    typedef enum logic [1:0] {
        CLS_BAD = 2'd0,
        CLS_REG = 2'd1,
        CLS_BUS = 2'd2
    } op_class_e;

    typedef struct packed {
        op_class_e cls;
        logic      reg_write;
        logic      wr_phase;
        logic      rd_phase;
    } op_info_t;

    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_REG_SETUP  = 3'd1,
        ST_REG_ACCESS = 3'd2,
        ST_BUS_REQ    = 3'd3,
        ST_BUS_TURN   = 3'd4,
        ST_FINISH     = 3'd5
    } disp_state_e;

    function automatic op_info_t classify_op(input logic [7:0] opc);
        op_info_t info;
        info.cls       = CLS_BAD;
        info.reg_write = 1'b0;
        info.wr_phase  = 1'b0;
        info.rd_phase  = 1'b0;
        case (opc)
            OPC_REG_RD:  info.cls = CLS_REG;
            OPC_REG_WR: begin
                info.cls       = CLS_REG;
                info.reg_write = 1'b1;
            end
            OPC_BUS_RD: begin
                info.cls      = CLS_BUS;
                info.rd_phase = 1'b1;
            end
            OPC_BUS_WR: begin
                info.cls      = CLS_BUS;
                info.wr_phase = 1'b1;
            end
            OPC_BUS_WRD: begin
                info.cls      = CLS_BUS;
                info.wr_phase = 1'b1;
                info.rd_phase = 1'b1;
            end
            default: info.cls = CLS_BAD;
        endcase
        return info;
    endfunction

endpackage

// File: rtl/pio_op_decode.sv
module pio_op_decode
    import pio_disp_pkg::*;
(
    input  logic [7:0] opc,
    output op_info_t   info
);

    always_comb begin
        info = classify_op(opc);
    end

endmodule

// File: rtl/pio_disp_fsm.sv
module pio_disp_fsm
    import pio_disp_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LEN_W  = 8,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_start,
    input  op_info_t          dec_info,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    input  logic [LEN_W-1:0]  cmd_wlen,
    input  logic [LEN_W-1:0]  cmd_rlen,
    output logic              cmd_done,
    output logic              cmd_err,
    output logic [DATA_W-1:0] cmd_rdata,
    output logic              reg_psel,
    output logic              reg_penable,
    output logic              reg_pwrite,
    output logic [ADDR_W-1:0] reg_paddr,
    output logic [DATA_W-1:0] reg_pwdata,
    input  logic [DATA_W-1:0] reg_prdata,
    input  logic              reg_pready,
    output logic              xreq_valid,
    output logic              xreq_read,
    output logic [LEN_W-1:0]  xreq_len,
    output logic [DATA_W-1:0] xreq_wdata,
    output logic              xreq_rstart,
    output logic              xreq_stop,
    input  logic              xrsp_done,
    input  logic              xrsp_err,
    input  logic [DATA_W-1:0] xrsp_rdata
);

    disp_state_e       state_q;
    op_info_t          info_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [LEN_W-1:0]  wlen_q;
    logic [LEN_W-1:0]  rlen_q;
    logic              in_rd_phase_q;
    logic              err_q;
    logic [DATA_W-1:0] result_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q       <= ST_IDLE;
            info_q        <= '0;
            addr_q        <= '0;
            wdata_q       <= '0;
            wlen_q        <= '0;
            rlen_q        <= '0;
            in_rd_phase_q <= 1'b0;
            err_q         <= 1'b0;
            result_q      <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (cmd_start) begin
                        info_q        <= dec_info;
                        addr_q        <= cmd_addr;
                        wdata_q       <= cmd_wdata;
                        wlen_q        <= cmd_wlen;
                        rlen_q        <= cmd_rlen;
                        result_q      <= '0;
                        err_q         <= 1'b0;
                        in_rd_phase_q <= !dec_info.wr_phase;
                        case (dec_info.cls)
                            CLS_REG: state_q <= ST_REG_SETUP;
                            CLS_BUS: state_q <= ST_BUS_REQ;
                            default: begin
                                err_q   <= 1'b1;
                                state_q <= ST_FINISH;
                            end
                        endcase
                    end
                end
                ST_REG_SETUP: state_q <= ST_REG_ACCESS;
                ST_REG_ACCESS: begin
                    if (reg_pready) begin
                        if (!info_q.reg_write) begin
                            result_q <= reg_prdata;
                        end
                        state_q <= ST_FINISH;
                    end
                end
                ST_BUS_REQ: begin
                    if (xrsp_done) begin
                        if (xrsp_err) begin
                            err_q   <= 1'b1;
                            state_q <= ST_FINISH;
                        end else if (in_rd_phase_q) begin
                            result_q <= xrsp_rdata;
                            state_q  <= ST_FINISH;
                        end else if (info_q.rd_phase) begin
                            in_rd_phase_q <= 1'b1;
                            state_q       <= ST_BUS_TURN;
                        end else begin
                            state_q <= ST_FINISH;
                        end
                    end
                end
                ST_BUS_TURN: state_q <= ST_BUS_REQ;
                ST_FINISH:   state_q <= ST_IDLE;
                default:     state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        cmd_done    = (state_q == ST_FINISH);
        cmd_err     = cmd_done && err_q;
        cmd_rdata   = result_q;
        reg_psel    = (state_q == ST_REG_SETUP) || (state_q == ST_REG_ACCESS);
        reg_penable = (state_q == ST_REG_ACCESS);
        reg_pwrite  = info_q.reg_write;
        reg_paddr   = addr_q;
        reg_pwdata  = wdata_q;
        xreq_valid  = (state_q == ST_BUS_REQ);
        xreq_read   = in_rd_phase_q;
        xreq_len    = in_rd_phase_q ? rlen_q : wlen_q;
        xreq_wdata  = wdata_q;
        xreq_rstart = in_rd_phase_q && info_q.wr_phase;
        xreq_stop   = in_rd_phase_q || !info_q.rd_phase;
    end

    // R12: completion strobe lasts one cycle
    p_done_pulse_r12: assert property (@(posedge clk) disable iff (rst)
        cmd_done |=> !cmd_done);

    // R2: setup cycle is followed by an access cycle
    p_setup_to_access_r2: assert property (@(posedge clk) disable iff (rst)
        (reg_psel && !reg_penable) |=> (reg_psel && reg_penable));

    // R2: access is held steady while the slave is not ready
    p_access_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (reg_psel && reg_penable && !reg_pready) |=>
        (reg_psel && reg_penable && $stable(reg_paddr) && $stable(reg_pwrite)));

    // R8: the two downstream ports are never active together
    p_one_port_r8: assert property (@(posedge clk) disable iff (rst)
        !(reg_psel && xreq_valid));

    // R7: a pending request keeps its fields until the engine answers
    p_req_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (xreq_valid && !xrsp_done) |=>
        (xreq_valid && $stable(xreq_read) && $stable(xreq_len) && $stable(xreq_stop)));

    // R7: a repeated start is only asked for on a final read phase
    p_rstart_read_r7: assert property (@(posedge clk) disable iff (rst)
        (xreq_valid && xreq_rstart) |-> (xreq_read && xreq_stop));

    // R9: an unknown opcode completes with error in the next cycle
    p_bad_op_r9: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && cmd_start && dec_info.cls == CLS_BAD) |=>
        (cmd_done && cmd_err && !reg_psel && !xreq_valid));

    // R10: an engine error ends the command without another phase
    p_err_abort_r10: assert property (@(posedge clk) disable iff (rst)
        (xreq_valid && xrsp_done && xrsp_err) |=>
        (cmd_done && cmd_err && !xreq_valid));

endmodule

// File: rtl/pio_dispatch.sv
module pio_dispatch
    import pio_disp_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LEN_W  = 8,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_start,
    input  logic [7:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    input  logic [LEN_W-1:0]  cmd_wlen,
    input  logic [LEN_W-1:0]  cmd_rlen,
    output logic              cmd_done,
    output logic              cmd_err,
    output logic [DATA_W-1:0] cmd_rdata,
    output logic              reg_psel,
    output logic              reg_penable,
    output logic              reg_pwrite,
    output logic [ADDR_W-1:0] reg_paddr,
    output logic [DATA_W-1:0] reg_pwdata,
    input  logic [DATA_W-1:0] reg_prdata,
    input  logic              reg_pready,
    output logic              xreq_valid,
    output logic              xreq_read,
    output logic [LEN_W-1:0]  xreq_len,
    output logic [DATA_W-1:0] xreq_wdata,
    output logic              xreq_rstart,
    output logic              xreq_stop,
    input  logic              xrsp_done,
    input  logic              xrsp_err,
    input  logic [DATA_W-1:0] xrsp_rdata
);

    op_info_t dec_info;

    pio_op_decode u_decode (
        .opc  (cmd_op),
        .info (dec_info)
    );

    pio_disp_fsm #(
        .DATA_W (DATA_W),
        .LEN_W  (LEN_W),
        .ADDR_W (ADDR_W)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .cmd_start   (cmd_start),
        .dec_info    (dec_info),
        .cmd_addr    (cmd_addr),
        .cmd_wdata   (cmd_wdata),
        .cmd_wlen    (cmd_wlen),
        .cmd_rlen    (cmd_rlen),
        .cmd_done    (cmd_done),
        .cmd_err     (cmd_err),
        .cmd_rdata   (cmd_rdata),
        .reg_psel    (reg_psel),
        .reg_penable (reg_penable),
        .reg_pwrite  (reg_pwrite),
        .reg_paddr   (reg_paddr),
        .reg_pwdata  (reg_pwdata),
        .reg_prdata  (reg_prdata),
        .reg_pready  (reg_pready),
        .xreq_valid  (xreq_valid),
        .xreq_read   (xreq_read),
        .xreq_len    (xreq_len),
        .xreq_wdata  (xreq_wdata),
        .xreq_rstart (xreq_rstart),
        .xreq_stop   (xreq_stop),
        .xrsp_done   (xrsp_done),
        .xrsp_err    (xrsp_err),
        .xrsp_rdata  (xrsp_rdata)
    );

endmodule

// File: tb/pio_dispatch_tb_top.sv
`timescale 1ns/1ps
module pio_dispatch_tb_top;

    localparam int DW = 32;
    localparam int LW = 8;
    localparam int AW = 8;

    typedef struct packed {
        logic [7:0]  op;
        logic [7:0]  addr;
        logic [31:0] wdata;
        logic [7:0]  wlen;
        logic [7:0]  rlen;
        logic        exp_err;
        logic [1:0]  exp_napb;
        logic [1:0]  exp_nreq;
    } vec_t;

    localparam int NVEC = 11;
    localparam vec_t VECS [NVEC] = '{
        '{8'h12, 8'h00, 32'h0000_0000, 8'd0, 8'd0, 1'b0, 2'd1, 2'd0},
        '{8'h12, 8'hFF, 32'h0000_0000, 8'd0, 8'd0, 1'b0, 2'd1, 2'd0},
        '{8'h13, 8'hFF, 32'hDEAD_BEEF, 8'd0, 8'd0, 1'b0, 2'd1, 2'd0},
        '{8'h13, 8'h00, 32'h1357_9BDF, 8'd0, 8'd0, 1'b0, 2'd1, 2'd0},
        '{8'h14, 8'h00, 32'h0000_0000, 8'd0, 8'd4, 1'b0, 2'd0, 2'd1},
        '{8'h14, 8'hFF, 32'h0000_0000, 8'd0, 8'd4, 1'b0, 2'd0, 2'd1},
        '{8'h18, 8'h5A, 32'hA1B2_C3D4, 8'd3, 8'd9, 1'b0, 2'd0, 2'd1},
        '{8'h1C, 8'h77, 32'h0102_0304, 8'd2, 8'd6, 1'b0, 2'd0, 2'd2},
        '{8'h00, 8'h12, 32'h0000_0000, 8'd1, 8'd1, 1'b1, 2'd0, 2'd0},
        '{8'h1D, 8'h00, 32'h0000_0000, 8'd1, 8'd1, 1'b1, 2'd0, 2'd0},
        '{8'hFF, 8'h13, 32'h0000_0000, 8'd1, 8'd1, 1'b1, 2'd0, 2'd0}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_start = 1'b0;
    logic [7:0]    cmd_op = '0;
    logic [AW-1:0] cmd_addr = '0;
    logic [DW-1:0] cmd_wdata = '0;
    logic [LW-1:0] cmd_wlen = '0;
    logic [LW-1:0] cmd_rlen = '0;
    logic          cmd_done, cmd_err;
    logic [DW-1:0] cmd_rdata;
    logic          reg_psel, reg_penable, reg_pwrite;
    logic [AW-1:0] reg_paddr;
    logic [DW-1:0] reg_pwdata;
    logic [DW-1:0] reg_prdata = '0;
    logic          reg_pready = 1'b0;
    logic          xreq_valid, xreq_read, xreq_rstart, xreq_stop;
    logic [LW-1:0] xreq_len;
    logic [DW-1:0] xreq_wdata;
    logic          xrsp_done = 1'b0;
    logic          xrsp_err = 1'b0;
    logic [DW-1:0] xrsp_rdata = '0;

    always #2 clk = ~clk;

    pio_dispatch #(.DATA_W(DW), .LEN_W(LW), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_wlen(cmd_wlen),
        .cmd_rlen(cmd_rlen), .cmd_done(cmd_done), .cmd_err(cmd_err),
        .cmd_rdata(cmd_rdata), .reg_psel(reg_psel), .reg_penable(reg_penable),
        .reg_pwrite(reg_pwrite), .reg_paddr(reg_paddr), .reg_pwdata(reg_pwdata),
        .reg_prdata(reg_prdata), .reg_pready(reg_pready),
        .xreq_valid(xreq_valid), .xreq_read(xreq_read), .xreq_len(xreq_len),
        .xreq_wdata(xreq_wdata), .xreq_rstart(xreq_rstart), .xreq_stop(xreq_stop),
        .xrsp_done(xrsp_done), .xrsp_err(xrsp_err), .xrsp_rdata(xrsp_rdata)
    );

    int n_checks = 0;
    int n_fail = 0;

    // models and monitors
    int          apb_wait = 0;
    int          apb_cnt = 0;
    int          apb_n = 0;
    logic [7:0]  apb_addr_seen;
    logic        apb_write_seen;
    logic [31:0] apb_wdata_seen;
    int          req_n = 0;
    int          inj_idx = 99;
    int          ncyc = 0;
    logic        eng_busy = 1'b0;
    int          eng_lat = 0;
    logic        rq_read [4];
    logic [7:0]  rq_len [4];
    logic        rq_rstart [4];
    logic        rq_stop [4];
    logic [31:0] rq_wdata [4];
    int          rq_seen_t [4];
    int          rq_done_t [4];

    function automatic logic [31:0] apb_fn(input logic [7:0] a);
        return {a, ~a, 16'hC35A};
    endfunction

    function automatic logic [31:0] bus_fn(input logic [7:0] n);
        return {8'h9E, n, ~n, 8'h21};
    endfunction

    always @(negedge clk) begin
        ncyc++;
        reg_pready = 1'b0;
        xrsp_done  = 1'b0;
        xrsp_err   = 1'b0;
        if (reg_psel && !reg_penable) begin
            apb_n++;
            apb_addr_seen  = reg_paddr;
            apb_write_seen = reg_pwrite;
            apb_wdata_seen = reg_pwdata;
            apb_cnt = 0;
        end else if (reg_psel && reg_penable) begin
            if (apb_cnt == apb_wait) begin
                reg_pready = 1'b1;
                reg_prdata = apb_fn(reg_paddr);
            end else begin
                apb_cnt++;
            end
        end
        if (xreq_valid && !eng_busy) begin
            if (req_n < 4) begin
                rq_read[req_n]   = xreq_read;
                rq_len[req_n]    = xreq_len;
                rq_rstart[req_n] = xreq_rstart;
                rq_stop[req_n]   = xreq_stop;
                rq_wdata[req_n]  = xreq_wdata;
                rq_seen_t[req_n] = ncyc;
            end
            eng_busy = 1'b1;
            eng_lat  = 2;
        end else if (eng_busy) begin
            if (eng_lat == 0) begin
                xrsp_done  = 1'b1;
                xrsp_err   = (req_n == inj_idx);
                xrsp_rdata = bus_fn(xreq_len);
                if (req_n < 4) rq_done_t[req_n] = ncyc;
                req_n++;
                eng_busy = 1'b0;
            end else begin
                eng_lat--;
            end
        end
    end

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic run_cmd(input logic [7:0] op, input logic [7:0] addr,
                           input logic [31:0] wd, input logic [7:0] wl,
                           input logic [7:0] rl, output logic got_err,
                           output logic [31:0] got_data, output int lat);
        apb_n = 0;
        req_n = 0;
        cmd_op = op; cmd_addr = addr; cmd_wdata = wd; cmd_wlen = wl; cmd_rlen = rl;
        cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        lat = 1;
        while (!cmd_done && lat < 500) begin
            @(negedge clk);
            lat++;
        end
        chk(cmd_done, "R12", "done seen", 32'(cmd_done), 32'd1);
        got_err  = cmd_err;
        got_data = cmd_rdata;
        @(negedge clk);
        chk(!cmd_done, "R12", "done one cycle", 32'(cmd_done), 32'd0);
    endtask

    logic        e;
    logic [31:0] d;
    int          lt;
    logic [31:0] exp_d;

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(!cmd_done && !cmd_err, "R1", "done/err after reset", {cmd_done, cmd_err}, 0);
        chk(!reg_psel && !reg_penable && !xreq_valid, "R1", "ports idle after reset",
            {reg_psel, reg_penable, xreq_valid}, 0);
        chk(cmd_rdata == 0, "R1", "rdata after reset", cmd_rdata, 0);

        for (int i = 0; i < NVEC; i++) begin
            vec_t v = VECS[i];
            run_cmd(v.op, v.addr, v.wdata, v.wlen, v.rlen, e, d, lt);
            case (v.op)
                8'h12:   exp_d = apb_fn(v.addr);
                8'h14:   exp_d = bus_fn(v.rlen);
                8'h1C:   exp_d = bus_fn(v.rlen);
                default: exp_d = 32'h0;
            endcase
            chk(e == v.exp_err, "R9", "error flag", 32'(e), 32'(v.exp_err));
            chk(d == exp_d, "R5", "result data", d, exp_d);
            chk(apb_n == int'(v.exp_napb), "R8", "register accesses", apb_n, 32'(v.exp_napb));
            chk(req_n == int'(v.exp_nreq), "R8", "bus requests", req_n, 32'(v.exp_nreq));
            case (v.op)
                8'h12, 8'h13: begin
                    chk(apb_addr_seen == v.addr, "R4", "paddr", apb_addr_seen, v.addr);
                    chk(apb_write_seen == (v.op == 8'h13), "R3", "pwrite",
                        32'(apb_write_seen), 32'(v.op == 8'h13));
                    chk(lt == 3, "R2", "register latency", lt, 3);
                    if (v.op == 8'h13)
                        chk(apb_wdata_seen == v.wdata, "R3", "pwdata", apb_wdata_seen, v.wdata);
                end
                8'h14: begin
                    chk(rq_read[0] && rq_stop[0] && !rq_rstart[0], "R5", "read flags",
                        {rq_read[0], rq_stop[0], rq_rstart[0]}, 3'b110);
                    chk(rq_len[0] == v.rlen, "R5", "read len", rq_len[0], v.rlen);
                end
                8'h18: begin
                    chk(!rq_read[0] && rq_stop[0] && !rq_rstart[0], "R6", "write flags",
                        {rq_read[0], rq_stop[0], rq_rstart[0]}, 3'b010);
                    chk(rq_len[0] == v.wlen, "R6", "write len", rq_len[0], v.wlen);
                    chk(rq_wdata[0] == v.wdata, "R6", "write bytes", rq_wdata[0], v.wdata);
                end
                8'h1C: begin
                    chk(!rq_read[0] && !rq_stop[0] && !rq_rstart[0], "R7", "phase1 flags",
                        {rq_read[0], rq_stop[0], rq_rstart[0]}, 3'b000);
                    chk(rq_len[0] == v.wlen, "R7", "phase1 len", rq_len[0], v.wlen);
                    chk(rq_read[1] && rq_stop[1] && rq_rstart[1], "R7", "phase2 flags",
                        {rq_read[1], rq_stop[1], rq_rstart[1]}, 3'b111);
                    chk(rq_len[1] == v.rlen, "R7", "phase2 len", rq_len[1], v.rlen);
                    chk(rq_seen_t[1] - rq_done_t[0] == 2, "R7", "one idle cycle between phases",
                        rq_seen_t[1] - rq_done_t[0], 2);
                end
                default: chk(lt == 1, "R9", "error latency", lt, 1);
            endcase
        end

        // R2: register read with wait states
        apb_wait = 3;
        run_cmd(8'h12, 8'h3C, 32'h0, 8'd0, 8'd0, e, d, lt);
        chk(lt == 6, "R2", "latency with 3 wait states", lt, 6);
        chk(d == apb_fn(8'h3C), "R2", "waited read data", d, apb_fn(8'h3C));
        apb_wait = 0;

        // R10: engine error on write phase of write-then-read
        inj_idx = 0;
        run_cmd(8'h1C, 8'h00, 32'h55, 8'd1, 8'd2, e, d, lt);
        chk(e == 1'b1, "R10", "error reported", 32'(e), 1);
        chk(req_n == 1, "R10", "no read phase after error", req_n, 1);
        chk(d == 0, "R10", "no data after error", d, 0);
        inj_idx = 99;

        // R11: start while busy is ignored
        apb_n = 0; req_n = 0;
        cmd_op = 8'h14; cmd_rlen = 8'd7; cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        @(negedge clk);
        cmd_op = 8'h13; cmd_addr = 8'h44; cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        lt = 0;
        while (!cmd_done && lt < 500) begin
            @(negedge clk);
            lt++;
        end
        chk(cmd_rdata == bus_fn(8'd7), "R11", "first command result", cmd_rdata, bus_fn(8'd7));
        repeat (6) @(negedge clk);
        chk(apb_n == 0, "R11", "busy start not accepted", apb_n, 0);
        chk(req_n == 1, "R11", "single request", req_n, 1);
        chk(!cmd_done, "R11", "no extra done", 32'(cmd_done), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule